// File: doc/BRIEF.md
# PHY Self-ID Quadlet Builder

This block assembles the local node's own self-ID quadlet for a serial bus whose link layer cannot obtain that quadlet from the PHY directly. On a start pulse it captures the node's 6-bit PHY ID. It then reads PHY registers 1 through 6, one at a time, over a link-to-PHY register access port, and packs selected bits of those registers into a 32-bit self-ID word. When the word is ready it is presented with a one-cycle done strobe.

Each read is a single-cycle request carrying a 4-bit register address. The PHY answers with a 32-bit response word whose bits 27:24 echo the address being answered and whose bits 23:16 carry the register data. Responses whose echo does not match the outstanding address are skipped. If no matching response arrives within a programmable number of cycles, the build is abandoned and an error strobe is raised in place of a result.

Every connected port is encoded as a 2-bit code, and at most three ports are reported. This keeps every port field inside the low byte and every port register index at or below 6.

Top module: `selfid_builder`

## Requirements
- R1: While reset is held and on the first cycle after it, `done`, `err` and `req_valid` are 0 and `result` is 0.
- R2: One build issues exactly six read requests, with addresses 1, 2, 3, 4, 5, 6 in that order. Each request is a single-cycle pulse of `req_valid`, and no new request is issued while one is outstanding.
- R3: A response is accepted only when `rsp_valid` is 1 and `rsp_word[27:24]` equals the outstanding address. The register value is taken from `rsp_word[23:16]`, and all other response bits, as well as non-matching responses, have no effect on the result.
- R4: In `result`, bit 31 = 1, bit 22 = 1, bits 29:24 = the PHY ID captured at start, and bits 30, 23, 13:12, 10:8 and 0 are 0.
- R5: `result[21:16]` = register 1 bits 5:0 (gap count) and `result[15:14]` = register 2 bits 7:6 (speed).
- R6: `result[11]` = register 6 bit 0 (contender) and `result[1]` = register 6 bit 4 (initiated reset).
- R7: Port i (i = 0, 1, 2) uses register 3+i, and its code sits at `result[7-2i:6-2i]`. The code is 2'b1b, with b = bit 3 of that register, when the register's bit 2 (connected) is 1, and 2'b01 otherwise.
- R8: The port count is register 2 bits 4:0 clamped to 3. The field of each port at or beyond that count is 2'b00.
- R9: Within one read, the wait cycles after the request are numbered from 0. If no matching response has been accepted by the end of wait cycle `tmo_limit`, `err` pulses for one cycle, `done` does not pulse and no further request is issued. A match in that final cycle wins over the timeout.
- R10: `done` is a one-cycle pulse. `result` changes only in the cycle `done` rises and is held until the next completed build. A `start` that arrives while a build is in progress is ignored, and the PHY ID is not re-captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a build (taken only when idle) |
| phy_id | input | 6 | Local PHY ID captured at start |
| tmo_limit | input | TMO_W | Index of the last wait cycle allowed per read |
| req_valid | output | 1 | One-cycle PHY register read request |
| req_addr | output | 4 | Address of the requested PHY register |
| rsp_valid | input | 1 | PHY response word valid |
| rsp_word | input | 32 | Response: echo address in 27:24, data in 23:16 |
| result | output | 32 | Packed self-ID quadlet |
| done | output | 1 | Result valid strobe |
| err | output | 1 | Build abandoned on read timeout |

## Verification
Two events can coincide: the acceptance of a matching echo and the expiry of the read timeout. Both can occur in wait cycle `tmo_limit`. The bench provokes the overlap by delaying the PHY answer to exactly that cycle, and expects a completed build with the correct quadlet and no error. Delaying the answer one cycle more must give an error strobe and no done. A start pulse issued in the middle of a build also coincides with the running sequence; it is judged by the request count and the captured PHY ID field.

// File: rtl/selfid_pkg.sv
package selfid_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int REG_DATA_W = 8;
    localparam int WORD_W     = 32;

    // PHY registers read for one build
    localparam int REG_FIRST  = 1;
    localparam int REG_LAST   = 6;
    localparam int NREG       = REG_LAST - REG_FIRST + 1;
    localparam int SLOT_W     = $clog2(NREG);

    // response word layout
    localparam int ECHO_LSB   = 24;
    localparam int DATA_LSB   = 16;

    // self-ID word layout
    localparam logic [WORD_W-1:0] SID_BASE = 32'h8040_0000;
    localparam int ID_LSB     = 24;
    localparam int ID_W       = 6;
    localparam int GAP_LSB    = 16;
    localparam int GAP_W      = 6;
    localparam int SPD_LSB    = 14;
    localparam int CONT_BIT   = 11;
    localparam int IRST_BIT   = 1;
    localparam int PORT_TOP   = 7;
    localparam int MAX_PORTS  = 3;
    localparam int PCNT_W     = $clog2(MAX_PORTS + 1);

    typedef logic [REG_DATA_W-1:0] phy_reg_t;
    typedef phy_reg_t [NREG-1:0]   reg_bank_t;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_ISSUE,
        RP_WAIT
    } rd_state_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_LAUNCH,
        SQ_WAIT,
        SQ_FINISH
    } seq_state_e;

    // 2-bit connection code of one port register
    function automatic logic [1:0] port_code(input phy_reg_t r);
        return r[2] ? {1'b1, r[3]} : 2'b01;
    endfunction

    // raw 5-bit port count limited to the fields that fit
    function automatic logic [PCNT_W-1:0] clamp_ports(input logic [4:0] raw);
        return (raw > 5'(MAX_PORTS)) ? PCNT_W'(MAX_PORTS) : PCNT_W'(raw);
    endfunction

endpackage

// File: rtl/phy_reg_reader.sv
module phy_reg_reader
    import selfid_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [REG_ADDR_W-1:0] addr,
    input  logic [TMO_W-1:0]      limit,
    input  logic                  rsp_valid,
    input  logic [WORD_W-1:0]     rsp_word,
    output logic                  req_valid,
    output logic [REG_ADDR_W-1:0] req_addr,
    output logic                  ok,
    output logic                  tmo,
    output phy_reg_t              data
);

    rd_state_e             st;
    logic [TMO_W-1:0]      cnt;
    logic [REG_ADDR_W-1:0] addr_q;
    logic                  echo_hit;
    logic                  unused_rsp;

    assign echo_hit   = rsp_valid && (rsp_word[ECHO_LSB +: REG_ADDR_W] == addr_q);
    assign unused_rsp = ^{rsp_word[WORD_W-1:ECHO_LSB+REG_ADDR_W], rsp_word[DATA_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= RP_IDLE;
            cnt    <= '0;
            addr_q <= '0;
            ok     <= 1'b0;
            tmo    <= 1'b0;
            data   <= '0;
        end else begin
            ok  <= 1'b0;
            tmo <= 1'b0;
            case (st)
                RP_IDLE: begin
                    if (go) begin
                        addr_q <= addr;
                        st     <= RP_ISSUE;
                    end
                end
                RP_ISSUE: begin
                    cnt <= '0;
                    st  <= RP_WAIT;
                end
                RP_WAIT: begin
                    if (echo_hit) begin
                        data <= rsp_word[DATA_LSB +: REG_DATA_W];
                        ok   <= 1'b1;
                        st   <= RP_IDLE;
                    end else if (cnt == limit) begin
                        tmo <= 1'b1;
                        st  <= RP_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RP_IDLE;
            endcase
        end
    end

    assign req_valid = (st == RP_ISSUE);
    assign req_addr  = addr_q;

endmodule

// File: rtl/selfid_seq.sv
module selfid_seq
    import selfid_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ID_W-1:0]       phy_id,
    input  logic                  rd_ok,
    input  logic                  rd_tmo,
    input  phy_reg_t              rd_data,
    output logic                  rd_go,
    output logic [REG_ADDR_W-1:0] rd_addr,
    output reg_bank_t             bank,
    output logic [ID_W-1:0]       id_q,
    output logic                  fin,
    output logic                  fail
);

    seq_state_e        st;
    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            slot <= '0;
            bank <= '0;
            id_q <= '0;
            fail <= 1'b0;
        end else begin
            fail <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (start) begin
                        id_q <= phy_id;
                        slot <= '0;
                        st   <= SQ_LAUNCH;
                    end
                end
                SQ_LAUNCH: st <= SQ_WAIT;
                SQ_WAIT: begin
                    if (rd_ok) begin
                        bank[slot] <= rd_data;
                        if (slot == SLOT_W'(NREG - 1)) begin
                            st <= SQ_FINISH;
                        end else begin
                            slot <= slot + 1'b1;
                            st   <= SQ_LAUNCH;
                        end
                    end else if (rd_tmo) begin
                        fail <= 1'b1;
                        st   <= SQ_IDLE;
                    end
                end
                SQ_FINISH: st <= SQ_IDLE;
                default:   st <= SQ_IDLE;
            endcase
        end
    end

    assign rd_go   = (st == SQ_LAUNCH);
    assign rd_addr = REG_ADDR_W'(slot) + REG_ADDR_W'(REG_FIRST);
    assign fin     = (st == SQ_FINISH);

endmodule

// File: rtl/selfid_pack.sv
module selfid_pack
    import selfid_pkg::*;
(
    input  reg_bank_t         bank,
    input  logic [ID_W-1:0]   id,
    output logic [WORD_W-1:0] word
);

    localparam int R1 = 1 - REG_FIRST;
    localparam int R2 = 2 - REG_FIRST;
    localparam int R3 = 3 - REG_FIRST;
    localparam int R6 = 6 - REG_FIRST;

    logic [PCNT_W-1:0]          nports;
    logic [MAX_PORTS-1:0][1:0]  codes;
    logic                       unused_bits;

    assign nports = clamp_ports(bank[R2][4:0]);

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        assign codes[p] = (nports > PCNT_W'(p)) ? port_code(bank[R3 + p]) : 2'b00;
    end

    always_comb begin
        word = SID_BASE;
        word[ID_LSB +: ID_W]   = id;
        word[GAP_LSB +: GAP_W] = bank[R1][GAP_W-1:0];
        word[SPD_LSB +: 2]     = bank[R2][7:6];
        word[CONT_BIT]         = bank[R6][0];
        word[IRST_BIT]         = bank[R6][4];
        for (int p = 0; p < MAX_PORTS; p++) begin
            word[PORT_TOP - 2*p -: 2] = codes[p];
        end
    end

    assign unused_bits = ^{bank[R1][7:6], bank[R2][5],
                           bank[R3][7:4], bank[R3][1:0],
                           bank[R3+1][7:4], bank[R3+1][1:0],
                           bank[R3+2][7:4], bank[R3+2][1:0],
                           bank[R6][7:5], bank[R6][3:1]};

endmodule

// File: rtl/selfid_builder.sv
module selfid_builder
    import selfid_pkg::*;
#(
    parameter int TMO_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [ID_W-1:0]       phy_id,
    input  logic [TMO_W-1:0]      tmo_limit,
    output logic                  req_valid,
    output logic [REG_ADDR_W-1:0] req_addr,
    input  logic                  rsp_valid,
    input  logic [WORD_W-1:0]     rsp_word,
    output logic [WORD_W-1:0]     result,
    output logic                  done,
    output logic                  err
);

    logic                  rd_go, rd_ok, rd_tmo, fin;
    logic [REG_ADDR_W-1:0] rd_addr;
    phy_reg_t              rd_data;
    reg_bank_t             bank;
    logic [ID_W-1:0]       id_q;
    logic [WORD_W-1:0]     packed_word;

    phy_reg_reader #(.TMO_W(TMO_W)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .go        (rd_go),
        .addr      (rd_addr),
        .limit     (tmo_limit),
        .rsp_valid (rsp_valid),
        .rsp_word  (rsp_word),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .ok        (rd_ok),
        .tmo       (rd_tmo),
        .data      (rd_data)
    );

    selfid_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .phy_id  (phy_id),
        .rd_ok   (rd_ok),
        .rd_tmo  (rd_tmo),
        .rd_data (rd_data),
        .rd_go   (rd_go),
        .rd_addr (rd_addr),
        .bank    (bank),
        .id_q    (id_q),
        .fin     (fin),
        .fail    (err)
    );

    selfid_pack u_pack (
        .bank (bank),
        .id   (id_q),
        .word (packed_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin;
            if (fin) result <= packed_word;
        end
    end

endmodule

// File: rtl/selfid_builder_chk.sv
module selfid_builder_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [3:0]  req_addr,
    input logic [31:0] result,
    input logic        done,
    input logic        err
);

    AST_REQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> !req_valid) else $error("request longer than one cycle"); // R2

    AST_REQ_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_addr >= 4'd1 && req_addr <= 4'd6)) else $error("request address out of range"); // R2

    AST_RESULT_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
        done |-> (result[31] && !result[30] && result[22] && !result[23] && !result[0]))
        else $error("fixed bits wrong"); // R4

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && err)) else $error("done and err together"); // R9

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        err |=> !err) else $error("err longer than one cycle"); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R10

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result)) else $error("result moved without done"); // R10

endmodule

bind selfid_builder selfid_builder_chk u_chk (.*);

// File: tb/tb_selfid_builder.sv
`timescale 1ns/1ps
module tb_selfid_builder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  phy_id = '0;
    logic [7:0]  tmo_limit = 8'd8;
    logic        req_valid;
    logic [3:0]  req_addr;
    logic        rsp_valid = 1'b0;
    logic [31:0] rsp_word = '0;
    logic [31:0] result;
    logic        done, err;

    always #2 clk = ~clk;

    selfid_builder #(.TMO_W(8)) dut (
        .clk(clk), .rst(rst), .start(start), .phy_id(phy_id),
        .tmo_limit(tmo_limit), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_word(rsp_word),
        .result(result), .done(done), .err(err)
    );

    int total = 0;
    int fails = 0;

    // PHY model state
    logic [7:0] phy_regs [1:6];
    int         dly = 1;
    bit         noise = 0;
    logic [3:0] drop_addr = 4'd0;
    bit         pend = 0;
    int         cd = 0;
    logic [3:0] pa = '0;
    int         nreq = 0;
    logic [3:0] req_log [0:15];

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        rsp_word  = 32'h0;
        if (pend) begin
            if (cd == 0) begin
                rsp_valid = 1'b1;
                rsp_word  = {4'hB, pa, phy_regs[pa], 16'h5AC3};
                pend = 0;
            end else begin
                cd = cd - 1;
                if (noise) begin
                    rsp_valid = 1'b1;
                    rsp_word  = {4'h0, pa ^ 4'h8, ~phy_regs[pa], 16'hFFFF};
                end
            end
        end
        if (req_valid && !rst) begin
            if (nreq < 16) req_log[nreq] = req_addr;
            nreq = nreq + 1;
            if (req_addr != drop_addr) begin
                pend = 1;
                pa   = req_addr;
                cd   = dly - 1;
            end
        end
    end

    task automatic chk(input bit c, input string req, input [31:0] act, input [31:0] exp);
        total++;
        if (!c) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic [31:0] xs(input [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        return t ^ (t << 5);
    endfunction

    function automatic [31:0] expect_word(input [5:0] pid);
        logic [31:0] e;
        int n;
        int code;
        e = 32'h8000_0000 + 32'h0040_0000 + pid * (2 ** 24);
        e = e + (phy_regs[1] % 64) * (2 ** 16) + (phy_regs[2] / 64) * (2 ** 14);
        e = e + (phy_regs[6] % 2) * (2 ** 11) + ((phy_regs[6] / 16) % 2) * 2;
        n = phy_regs[2] % 32;
        if (n > 3) n = 3;
        for (int i = 0; i < n; i++) begin
            if ((phy_regs[3+i] / 4) % 2 == 1) code = 2 + (phy_regs[3+i] / 8) % 2;
            else code = 1;
            e = e + code * (2 ** (6 - 2*i));
        end
        return e;
    endfunction

    bit        got_done, got_err;
    logic [31:0] got_res;

    task automatic run(input [5:0] pid, input int d, input bit nz, input [3:0] drop,
                       input [7:0] lim, input bit mid_start);
        dly = d; noise = nz; drop_addr = drop; tmo_limit = lim; nreq = 0;
        got_done = 0; got_err = 0;
        @(negedge clk);
        start = 1'b1; phy_id = pid;
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 3000; c++) begin
            if (done || err) break;
            if (mid_start && c == 4) begin
                start = 1'b1; phy_id = ~pid;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        got_done = done; got_err = err; got_res = result;
        if (!done && !err) chk(0, "R9 run ended without done or err", 0, 1);
    endtask

    task automatic check_fields(input [5:0] pid, input bit clamp_case);
        logic [31:0] e;
        e = expect_word(pid);
        chk(got_done && !got_err, "R10 done expected", {30'd0, got_err, got_done}, 32'd1);
        chk(nreq == 6, "R2 request count", nreq, 6);
        for (int i = 0; i < 6; i++)
            chk(req_log[i] == 4'(i + 1), "R2 request order", req_log[i], i + 1);
        chk((got_res & 32'hFFC0_3701) == (e & 32'hFFC0_3701), "R4 id and fixed bits", got_res, e);
        chk((got_res & 32'h003F_C000) == (e & 32'h003F_C000), "R5 gap and speed", got_res, e);
        chk((got_res & 32'h0000_0802) == (e & 32'h0000_0802), "R6 contender and reset flag", got_res, e);
        if (clamp_case)
            chk((got_res & 32'hFC) == (e & 32'hFC), "R8 clamped port fields", got_res, e);
        else
            chk((got_res & 32'hFC) == (e & 32'hFC), "R7 port fields", got_res, e);
        if (noise)
            chk(got_res == e, "R3 mismatched echo ignored", got_res, e);
    endtask

    logic [31:0] seed;
    logic [31:0] hold;
    int cnt_sel [0:7] = '{0, 1, 2, 3, 4, 7, 16, 31};

    initial begin
        repeat (3) @(negedge clk);
        chk(!done && !err && !req_valid && result == 0, "R1 reset state",
            {result[28:0], req_valid, err, done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !err && !req_valid && result == 0, "R1 after reset",
            {result[28:0], req_valid, err, done}, 0);

        // sweep over port counts, port states, delays and echo noise
        seed = 32'h1234_5678;
        for (int k = 0; k < 96; k++) begin
            for (int r = 1; r <= 6; r++) begin
                seed = xs(seed);
                phy_regs[r] = seed[7:0];
            end
            phy_regs[2] = {2'(k % 4), seed[13], 5'(cnt_sel[k % 8])};
            run(6'(k * 5 + 3), 1 + (k % 3), bit'((k / 3) % 2), 4'd0, 8'd8, 0);
            check_fields(6'(k * 5 + 3), cnt_sel[k % 8] > 3);
        end

        // each port in each state, three ports
        for (int m = 0; m < 27; m++) begin
            phy_regs[1] = 8'h3F; phy_regs[2] = 8'hC3; phy_regs[6] = 8'h11;
            phy_regs[3] = (m % 3 == 0) ? 8'h00 : (m % 3 == 1) ? 8'h04 : 8'h0C;
            phy_regs[4] = ((m/3) % 3 == 0) ? 8'hF3 : ((m/3) % 3 == 1) ? 8'hF7 : 8'hFF;
            phy_regs[5] = ((m/9) % 3 == 0) ? 8'h08 : ((m/9) % 3 == 1) ? 8'h04 : 8'h0C;
            run(6'd63, 1, 0, 4'd0, 8'd2, 0);
            check_fields(6'd63, 0);
        end

        // match in the final allowed wait cycle wins over the timeout
        run(6'd9, 5, 0, 4'd0, 8'd4, 0);
        chk(got_done && !got_err, "R9 match on last wait cycle", {got_err, got_done}, 1);
        chk(got_res == expect_word(6'd9), "R9 result at boundary", got_res, expect_word(6'd9));
        run(6'd9, 1, 0, 4'd0, 8'd0, 0);
        chk(got_done && !got_err, "R9 zero limit immediate answer", {got_err, got_done}, 1);

        // one cycle too late
        hold = result;
        run(6'd9, 6, 0, 4'd0, 8'd4, 0);
        chk(got_err && !got_done, "R9 late answer gives err", {got_err, got_done}, 2);
        chk(result == hold, "R10 result held over error", result, hold);
        @(negedge clk);
        chk(!err, "R9 err is a pulse", err, 0);
        repeat (20) @(negedge clk);

        // dropped register stops the sequence
        run(6'd17, 1, 1, 4'd4, 8'd3, 0);
        chk(got_err && !got_done, "R9 dropped read gives err", {got_err, got_done}, 2);
        repeat (8) @(negedge clk);
        chk(nreq == 4, "R9 no request after timeout", nreq, 4);

        // start during a build is ignored
        phy_regs[2] = 8'h42;
        run(6'd21, 2, 0, 4'd0, 8'd8, 1);
        chk(nreq == 6, "R10 mid-build start no restart", nreq, 6);
        chk(got_res[29:24] == 6'd21, "R10 mid-build start id kept", got_res[29:24], 21);
        hold = result;
        @(negedge clk);
        chk(!done, "R10 done is a pulse", done, 0);
        repeat (6) @(negedge clk);
        chk(result == hold && !done, "R10 result held after done", result, hold);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog R9 run hung actual=%0d expected=0", 1);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule